// File: doc/BRIEF.md
# Packet Slot Page Allocator

This block keeps track of the slots of an on-chip packet memory. With the default parameters that is four slots of 2 KB each. Software asks for a transmit slot by issuing an allocate command with a size code. A size code is the number of 256-byte pages minus one. The block answers some cycles later: it writes a result register with the granted slot number or a failure flag, and it raises a sticky allocation interrupt bit.

Slots go back to the free pool in three ways: a free command names a transmit slot, a release command gives back the oldest received slot, and a reset command returns every slot and empties both queues. The receive datapath is modelled by a single strobe. Each strobe claims a free slot and appends its number to a receive queue. Software reads the head of that queue and its empty flag.

An enqueue command places the selected packet number on a transmit queue. A completion strobe from the transmit side retires the head of that queue and raises a transmit interrupt bit. Every command keeps a busy flag high for a fixed number of cycles. Its effect becomes visible in the cycle the flag drops.

Top module: `pkt_page_alloc`

## Requirements
- R1: An allocate command (opcode 2) with a size code from 0 to 7 grants the lowest-numbered free slot. The slot number is placed in `alloc_result[NUM_W-1:0]`, the failure bit `alloc_result[NUM_W]` is cleared, and the slot leaves the free pool.
- R2: An allocate command whose size code is 8 to 15, or that finds no free slot, sets the failure bit and writes slot number 0. It consumes no slot.
- R3: Every completed allocate command sets `alloc_int`. The bit stays set until `int_ack[0]` is driven to one. If a completion and an acknowledge fall in the same cycle, the completion wins.
- R4: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` then stays high for exactly BUSY_CYCLES cycles (3 by default), and the command's effect appears in the cycle `busy` falls. A command presented while `busy` is high has no effect. Opcodes: 1 reset, 2 allocate, 3 enqueue, 4 free, 5 release; 0, 6 and 7 do nothing.
- R5: `mem_info[15:8]` gives the number of free slots and `mem_info[7:0]` gives the total number of slots, both in 2 KB units.
- R6: A reset command marks every slot free and empties the receive queue and the transmit queue.
- R7: Each `rx_push` pulse claims the lowest free slot left after a same-cycle allocation and appends that slot to the receive queue. `rx_head` shows the oldest entry and `rx_empty` is high when the queue holds nothing. When no slot is free the pulse is ignored.
- R8: A release command (opcode 5) frees the slot at the head of the receive queue and pops it. If the queue is empty, it has no effect.
- R9: A free command (opcode 4) returns slot `tx_sel` to the pool. A number of NUM_SLOTS or more, or a slot that is already free, has no effect.
- R10: An enqueue command (opcode 3) appends `tx_sel` to the transmit queue. `tx_pending` and `tx_head` show the queue. A `tx_done` pulse pops the head when the queue is not empty and sets `tx_int`, which `int_ack[1]` clears. A `tx_done` pulse on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_size | input | 4 | Allocate size code (pages minus one) |
| tx_sel | input | NUM_W | Selected transmit packet number |
| int_ack | input | 2 | Write-one-to-clear: bit 0 for the allocation interrupt, bit 1 for the transmit interrupt |
| rx_push | input | 1 | A received packet needs a slot |
| tx_done | input | 1 | Transmission of the queue head finished |
| busy | output | 1 | A command is executing |
| alloc_int | output | 1 | Allocation completed |
| tx_int | output | 1 | A transmission completed |
| alloc_result | output | NUM_W+1 | Failure bit on top, granted slot number below |
| mem_info | output | 16 | Free slot count (upper byte) and total slot count (lower byte) |
| rx_head | output | NUM_W | Oldest received slot number, 0 when the queue is empty |
| rx_empty | output | 1 | Receive queue empty |
| tx_head | output | NUM_W | Oldest queued transmit number |
| tx_pending | output | 1 | Transmit queue not empty |

## Verification
The bench drives the pool from full to empty and back. A design that leaks or double-counts slots shows it in the free count: an oversize request that still takes a slot, a second free of the same slot that adds to the count, or a free of an out-of-range number that does either. The bench presents a reset command while another command is busy; a design that accepts it empties the pool. It drives an acknowledge in the same cycle as an allocation completes; a design that lets the clear win loses the interrupt. It also pulses `rx_push` in the exact cycle an allocation executes; a design that runs the two pickers independently hands the same slot to both. Finally it overfills the receive side and releases from an empty queue, which exposes phantom queue entries.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_RESET   = 3'd1,
      OP_ALLOC   = 3'd2,
      OP_ENQ     = 3'd3,
      OP_FREE    = 3'd4,
      OP_RELEASE = 3'd5
   } pa_op_e;

   // Largest legal size code: eight 256-byte pages fill one slot.
   localparam int unsigned MAX_SIZE_CODE = 7;
endpackage

// File: rtl/pa_cmd_seq.sv
module pa_cmd_seq
   import pa_pkg::*;
#(
   parameter int BUSY_CYCLES = 3,
   parameter int SIZE_W      = 4,
   parameter int NUM_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic [NUM_W-1:0]  cmd_sel,
   output logic              busy,
   output logic              exec,
   output pa_op_e            op_q,
   output logic [SIZE_W-1:0] size_q,
   output logic [NUM_W-1:0]  sel_q
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   initial assert (BUSY_CYCLES >= 1) else $fatal(1, "BUSY_CYCLES must be at least 1");

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt_q  <= '0;
         op_q   <= OP_NOP;
         size_q <= '0;
         sel_q  <= '0;
      end else if (!busy) begin
         if (cmd_valid) begin
            busy   <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
            op_q   <= pa_op_e'(cmd_op);
            size_q <= cmd_size;
            sel_q  <= cmd_sel;
         end
      end else if (cnt_q == '0) begin
         busy <= 1'b0;
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign exec = busy && (cnt_q == '0);
endmodule

// File: rtl/pa_pick.sv
module pa_pick #(
   parameter int N      = 4,
   parameter bit LOWEST = 1'b1,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     mask,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   assign found = |mask;

   generate
      if (LOWEST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (mask[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (mask[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pa_slot_map.sv
module pa_slot_map #(
   parameter int NUM_SLOTS   = 4,
   parameter bit PICK_LOWEST = 1'b1,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take_a,
   input  logic              take_b,
   input  logic              give_en,
   input  logic [SLOT_W-1:0] give_idx,
   output logic              a_ok,
   output logic [SLOT_W-1:0] a_idx,
   output logic              b_ok,
   output logic [SLOT_W-1:0] b_idx,
   output logic [CNT_W-1:0]  free_cnt
);
   logic [NUM_SLOTS-1:0] free_q, a_oh, b_oh, give_oh, b_mask;

   pa_pick #(.N(NUM_SLOTS), .LOWEST(PICK_LOWEST)) u_pick_a (
      .mask(free_q), .found(a_ok), .idx(a_idx));

   assign a_oh   = (take_a && a_ok) ? (NUM_SLOTS'(1) << a_idx) : '0;
   assign b_mask = free_q & ~a_oh;

   pa_pick #(.N(NUM_SLOTS), .LOWEST(PICK_LOWEST)) u_pick_b (
      .mask(b_mask), .found(b_ok), .idx(b_idx));

   assign b_oh    = (take_b && b_ok) ? (NUM_SLOTS'(1) << b_idx) : '0;
   // Only slots in use may be returned; this keeps a stale free from
   // colliding with a same-cycle claim.
   assign give_oh = give_en ? ((NUM_SLOTS'(1) << give_idx) & ~free_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   free_q <= '1;
      else if (clr) free_q <= '1;
      else          free_q <= (free_q & ~a_oh & ~b_oh) | give_oh;
   end

   assign free_cnt = CNT_W'($countones(free_q));
endmodule

// File: rtl/pa_num_fifo.sv
module pa_num_fifo #(
   parameter int W     = 6,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int PTR_W = $clog2(DEPTH);

   initial assert (DEPTH >= 2 && (1 << PTR_W) == DEPTH)
      else $fatal(1, "queue depth must be a power of two");

   logic [W-1:0]   mem [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [PTR_W:0]   cnt_q;
   logic             do_push, do_pop, full;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (PTR_W+1)'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && !full;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + PTR_W'(1);
         if (do_pop)  rd_q <= rd_q + PTR_W'(1);
         cnt_q <= cnt_q + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
      end
   end

   assign dout = empty ? '0 : mem[rd_q];
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
   import pa_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int NUM_W       = 6,
   parameter int SIZE_W      = 4,
   parameter int BUSY_CYCLES = 3,
   parameter int TXQ_DEPTH   = 4,
   parameter bit PICK_LOWEST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic [NUM_W-1:0]  tx_sel,
   input  logic [1:0]        int_ack,
   input  logic              rx_push,
   input  logic              tx_done,
   output logic              busy,
   output logic              alloc_int,
   output logic              tx_int,
   output logic [NUM_W:0]    alloc_result,
   output logic [15:0]       mem_info,
   output logic [NUM_W-1:0]  rx_head,
   output logic              rx_empty,
   output logic [NUM_W-1:0]  tx_head,
   output logic              tx_pending
);
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int CNT_W  = $clog2(NUM_SLOTS + 1);

   initial begin
      assert (NUM_SLOTS >= 2 && NUM_SLOTS <= 255) else $fatal(1, "NUM_SLOTS out of range");
      assert (NUM_W >= SLOT_W) else $fatal(1, "NUM_W too narrow for slot numbers");
      assert (SIZE_W >= 3) else $fatal(1, "SIZE_W must cover codes 0..7");
   end

   logic              exec;
   pa_op_e            op_q;
   logic [SIZE_W-1:0] size_q;
   logic [NUM_W-1:0]  sel_q;

   pa_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES), .SIZE_W(SIZE_W), .NUM_W(NUM_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_size(cmd_size), .cmd_sel(tx_sel), .busy(busy), .exec(exec),
      .op_q(op_q), .size_q(size_q), .sel_q(sel_q));

   logic ex_reset, ex_alloc, ex_enq, ex_free, ex_rel, size_ok, sel_ok;
   assign ex_reset = exec && (op_q == OP_RESET);
   assign ex_alloc = exec && (op_q == OP_ALLOC);
   assign ex_enq   = exec && (op_q == OP_ENQ);
   assign ex_free  = exec && (op_q == OP_FREE);
   assign ex_rel   = exec && (op_q == OP_RELEASE);
   assign size_ok  = (size_q <= SIZE_W'(MAX_SIZE_CODE));
   assign sel_ok   = (sel_q < NUM_W'(NUM_SLOTS));

   logic              a_ok, b_ok, take_a, take_b, give_en;
   logic [SLOT_W-1:0] a_idx, b_idx, give_idx;
   logic [CNT_W-1:0]  free_cnt;

   assign take_a   = ex_alloc && size_ok;
   assign take_b   = rx_push && !ex_reset;
   assign give_en  = (ex_free && sel_ok) || (ex_rel && !rx_empty);
   assign give_idx = ex_rel ? rx_head[SLOT_W-1:0] : sel_q[SLOT_W-1:0];

   pa_slot_map #(.NUM_SLOTS(NUM_SLOTS), .PICK_LOWEST(PICK_LOWEST)) u_map (
      .clk(clk), .rst_n(rst_n), .clr(ex_reset), .take_a(take_a), .take_b(take_b),
      .give_en(give_en), .give_idx(give_idx), .a_ok(a_ok), .a_idx(a_idx),
      .b_ok(b_ok), .b_idx(b_idx), .free_cnt(free_cnt));

   pa_num_fifo #(.W(NUM_W), .DEPTH(NUM_SLOTS)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(ex_reset), .push(take_b && b_ok),
      .din(NUM_W'(b_idx)), .pop(ex_rel), .dout(rx_head), .empty(rx_empty));

   logic tx_empty, tx_retire;
   assign tx_retire = tx_done && !tx_empty && !ex_reset;

   pa_num_fifo #(.W(NUM_W), .DEPTH(TXQ_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(ex_reset), .push(ex_enq), .din(sel_q),
      .pop(tx_retire), .dout(tx_head), .empty(tx_empty));

   assign tx_pending = !tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_result <= '0;
         alloc_int    <= 1'b0;
         tx_int       <= 1'b0;
      end else begin
         if (ex_alloc) begin
            alloc_result <= (take_a && a_ok) ? {1'b0, NUM_W'(a_idx)} : {1'b1, {NUM_W{1'b0}}};
            alloc_int    <= 1'b1;
         end else if (int_ack[0]) begin
            alloc_int <= 1'b0;
         end
         if (tx_retire)       tx_int <= 1'b1;
         else if (int_ack[1]) tx_int <= 1'b0;
      end
   end

   assign mem_info = {8'(free_cnt), 8'(NUM_SLOTS)};
endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
   parameter int NUM_SLOTS   = 4,
   parameter int NUM_W       = 6,
   parameter int BUSY_CYCLES = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           alloc_int,
   input logic           tx_int,
   input logic [1:0]     int_ack,
   input logic           rx_push,
   input logic           rx_empty,
   input logic           tx_done,
   input logic [NUM_W:0] alloc_result,
   input logic [15:0]    mem_info
);
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   // R4: busy lasts exactly the configured number of cycles
   a_r4_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_len == BUSY_CYCLES);

   a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= BUSY_CYCLES);

   // R3: the allocation interrupt is sticky until acknowledged
   a_r3_alloc_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_int && !int_ack[0] |=> alloc_int);

   // R2: a failed result never carries a slot number
   a_r2_fail_num_zero: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_result[NUM_W] |-> alloc_result[NUM_W-1:0] == '0);

   // R5: free count never exceeds the total
   a_r5_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      mem_info[15:8] <= mem_info[7:0]);

   // R7: the receive queue only fills through rx_push
   a_r7_rx_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty && !rx_push |=> rx_empty);

   // R10: the transmit interrupt only rises after a completion strobe
   a_r10_tx_int_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_int) |-> $past(tx_done));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
   .NUM_SLOTS(NUM_SLOTS), .NUM_W(NUM_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .alloc_int(alloc_int), .tx_int(tx_int),
   .int_ack(int_ack), .rx_push(rx_push), .rx_empty(rx_empty), .tx_done(tx_done),
   .alloc_result(alloc_result), .mem_info(mem_info));

// File: tb/sim_pkt_page_alloc.sv
`timescale 1ns/1ps
module sim_pkt_page_alloc;
   localparam int NW   = 6;
   localparam int FAIL = 64;   // failure bit at alloc_result[6]

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, rx_push = 1'b0, tx_done = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_size = '0;
   logic [NW-1:0] tx_sel = '0;
   logic [1:0] int_ack = '0;
   logic busy, alloc_int, tx_int, rx_empty, tx_pending;
   logic [NW:0] alloc_result;
   logic [15:0] mem_info;
   logic [NW-1:0] rx_head, tx_head;

   always #2.5 clk = ~clk;

   pkt_page_alloc u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_size(cmd_size), .tx_sel(tx_sel), .int_ack(int_ack), .rx_push(rx_push),
      .tx_done(tx_done), .busy(busy), .alloc_int(alloc_int), .tx_int(tx_int),
      .alloc_result(alloc_result), .mem_info(mem_info), .rx_head(rx_head),
      .rx_empty(rx_empty), .tx_head(tx_head), .tx_pending(tx_pending));

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 50000);
         summary();
      end
   end

   // issues one command and waits for busy to drop; returns the busy length
   task automatic do_cmd(input int op, input int size, input int sel, output int blen);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_size = 4'(size); tx_sel = NW'(sel);
      @(negedge clk);
      cmd_valid = 1'b0;
      blen = 0;
      while (busy) begin
         blen++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_rx();
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
   endtask

   task automatic ack(input int bits);
      @(negedge clk); int_ack = 2'(bits);
      @(negedge clk); int_ack = '0;
   endtask

   // vector table: opcode, size code, select, expected result, expected free slots
   localparam int NV = 13;
   localparam int V_OP  [NV] = '{2, 2, 2, 4, 2, 2, 2, 2, 4, 4, 4, 2, 2};
   localparam int V_SZ  [NV] = '{0, 7, 8, 0, 3, 1, 2, 0, 0, 0, 0, 15, 5};
   localparam int V_SEL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 9, 2, 2, 0, 0};
   localparam int V_RES [NV] = '{0, 1, FAIL, FAIL, 0, 2, 3, FAIL, FAIL, FAIL, FAIL, FAIL, 2};
   localparam int V_FREE[NV] = '{3, 2, 2, 3, 2, 1, 0, 0, 0, 1, 1, 1, 0};

   initial begin
      int bl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset busy", int'(busy), 0);
      chk("R3 reset alloc_int", int'(alloc_int), 0);
      chk("R5 reset mem_info", int'(mem_info), 16'h0404);
      chk("R7 reset rx_empty", int'(rx_empty), 1);
      chk("R10 reset tx_pending", int'(tx_pending), 0);

      for (int i = 0; i < NV; i++) begin
         do_cmd(V_OP[i], V_SZ[i], V_SEL[i], bl);
         chk("R4 busy length", bl, 3);
         chk(V_RES[i] == FAIL ? "R2 result" : "R1 result", int'(alloc_result), V_RES[i]);
         chk(V_OP[i] == 4 ? "R9 free count" : "R5 free count", int'(mem_info[15:8]), V_FREE[i]);
         if (V_OP[i] == 2) begin
            chk("R3 alloc_int set", int'(alloc_int), 1);
            ack(1);
            chk("R3 alloc_int cleared", int'(alloc_int), 0);
         end
      end

      // R4: a command presented while busy is ignored
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd4; tx_sel = NW'(3);
      @(negedge clk); cmd_op = 3'd1;
      @(negedge clk); cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      chk("R4 ignored while busy", int'(mem_info[15:8]), 1);
      chk("R4 no second command", int'(busy), 0);

      // R3: sticky until acknowledged
      do_cmd(2, 0, 0, bl);
      chk("R1 regrant slot3", int'(alloc_result), 3);
      repeat (3) @(negedge clk);
      chk("R3 sticky", int'(alloc_int), 1);
      ack(1);
      // R3: completion wins over a same-cycle acknowledge
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd2; cmd_size = '0;
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk); int_ack = 2'b01;
      @(negedge clk); int_ack = '0;
      chk("R3 set beats clear", int'(alloc_int), 1);
      chk("R2 no slot left", int'(alloc_result), FAIL);
      ack(1);

      // R6: reset returns slots and clears queues
      do_cmd(3, 0, 1, bl);
      chk("R10 enqueue pending", int'(tx_pending), 1);
      do_cmd(1, 0, 0, bl);
      chk("R6 all free", int'(mem_info[15:8]), 4);
      chk("R6 tx queue empty", int'(tx_pending), 0);
      chk("R6 rx queue empty", int'(rx_empty), 1);

      // R7 / R8: receive queue
      pulse_rx();
      pulse_rx();
      chk("R7 rx head", int'(rx_head), 0);
      chk("R7 rx claims", int'(mem_info[15:8]), 2);
      do_cmd(5, 0, 0, bl);
      chk("R8 release head", int'(rx_head), 1);
      chk("R8 release frees", int'(mem_info[15:8]), 3);
      do_cmd(5, 0, 0, bl);
      chk("R8 queue drained", int'(rx_empty), 1);
      do_cmd(5, 0, 0, bl);
      chk("R8 release on empty", int'(mem_info[15:8]), 4);
      chk("R8 still empty", int'(rx_empty), 1);

      // R7: overfill, the fifth pulse finds no slot
      for (int k = 0; k < 5; k++) pulse_rx();
      chk("R7 pool exhausted", int'(mem_info[15:8]), 0);
      for (int k = 0; k < 4; k++) do_cmd(5, 0, 0, bl);
      chk("R7 extra push ignored", int'(rx_empty), 1);
      chk("R7 all returned", int'(mem_info[15:8]), 4);

      // R7: receive claim in the cycle an allocation executes
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd2; cmd_size = '0;
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
      chk("R1 alloc gets lowest", int'(alloc_result), 0);
      chk("R7 rx takes next slot", int'(rx_head), 1);
      chk("R7 two slots used", int'(mem_info[15:8]), 2);
      ack(1);

      // R10: transmit queue
      do_cmd(3, 0, 5, bl);
      do_cmd(3, 0, 2, bl);
      chk("R10 head first", int'(tx_head), 5);
      pulse_done();
      chk("R10 tx_int set", int'(tx_int), 1);
      chk("R10 head advances", int'(tx_head), 2);
      ack(2);
      chk("R10 tx_int cleared", int'(tx_int), 0);
      pulse_done();
      chk("R10 queue empty", int'(tx_pending), 0);
      ack(2);
      pulse_done();
      chk("R10 done on empty", int'(tx_int), 0);

      done = 1'b1;
      summary();
   end
endmodule